// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block produces the CPU-domain and PCI-domain clock outputs of a clock generator from a single master clock. The master clock runs at twice the CPU output rate. Every output is the Q of a flop on the master clock, so no output can glitch. A two-bit phase counter sets the timing. CPU outputs toggle on every master edge. PCI outputs run at half the CPU rate and rise on the same edge as a CPU rising edge. The outputs form three groups: the CPU outputs, the stoppable PCI outputs, and one free-running PCI output.

Three asynchronous requests control the groups: stop the CPU group, stop the stoppable PCI group, and power down everything. Each request passes through a two-flop synchronizer. Each group has its own gate state machine with three states:
- `GS_RUN`: outputs pass.
- `GS_DRAIN`: a CPU stop has been seen and a fixed number of pulses is still emitted.
- `GS_HALT`: outputs are held low.

The transitions are:
- run-to-drain: a request is seen while running, and the latency is non-zero.
- run-to-halt: a request is seen while running, and the latency is zero.
- drain-to-halt: the drain count has expired.
- drain-to-run: the request is withdrawn during the drain.
- halt-to-run: the request is withdrawn.

A state machine moves only on its group's boundary edge, the edge after which the group's output must be low. A stop therefore never cuts a high phase, and a restart always follows a full low phase. When the bypass input is high, all three requests are ignored. A configuration word holds per-output enable bits. It is written synchronously, and each group copies its bits only on its own boundary edge.

Top module: `ckstop_ctrl`

## Requirements
- R1: While `rst_n` is low, all outputs are low. On the first master edge after release, all CPU outputs, all PCI outputs and the free PCI output go high. On the second edge the CPU outputs fall while the PCI outputs stay high. On the third edge the CPU outputs rise and the PCI outputs fall.
- R2: A running CPU output is high for one master cycle and low for one. A running PCI output, stoppable or free, is high for two master cycles and low for two. Its rising edges coincide with CPU rising edges.
- R3: A CPU stop request passes a two-flop synchronizer. At the next CPU boundary edge, the CPU group enters its drain state. It emits exactly `CPU_STOP_LAT` (default 2) more high pulses and is then held low.
- R4: When the CPU stop request is withdrawn, the CPU group returns to run at the next CPU boundary. The first high pulse after release follows a full one-cycle low phase.
- R5: A synchronized PCI stop request holds every stoppable PCI output low, starting at the next rising edge of the free PCI output. The release takes effect on a free PCI rising edge as well. The free PCI output keeps toggling throughout.
- R6: A synchronized power-down request holds all outputs low: the CPU outputs after the CPU stop latency, and the stoppable and free PCI outputs from the next free PCI rising edge.
- R7: While `pm_bypass` is high, the CPU stop, PCI stop and power-down inputs have no effect, and all groups run.
- R8: Configuration word layout:
  - bits 3:0: CPU outputs 0 to 3.
  - bits 9:4: stoppable PCI outputs 0 to 5.
  - bit 10: the free PCI output.
  - bits 15:11: reserved and ignored.
  A cleared bit forces its output low from the group's next boundary. The reset value enables every output.
- R9: No CPU output ever shows a high phase longer than one master cycle. No PCI output ever shows a high or low phase shorter than two master cycles. A group's state changes only on that group's boundary edge.
- R10: If the CPU stop request is withdrawn before the drain completes, the CPU group returns to run without dropping any pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Master clock, twice the CPU output rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_bypass | input | 1 | High: the stop and power-down requests are ignored |
| cpu_stop_a | input | 1 | Asynchronous CPU group stop request |
| pci_stop_a | input | 1 | Asynchronous stoppable PCI group stop request |
| pwr_down_a | input | 1 | Asynchronous power-down request |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word write data |
| cpu_clk_o | output | 4 | CPU clock outputs |
| pci_clk_o | output | 6 | Stoppable PCI clock outputs |
| pci_free_o | output | 1 | Free-running PCI clock output |

## Verification
A wrong phase counter value shows up at the ports within one master cycle, either as a CPU or PCI edge out of line with the other group or as a PCI phase of the wrong length. A gate state machine stuck in the wrong state, or moving off its boundary, shows within one group period as a missing pulse, an extra pulse or a shortened phase. The bench compares every output with its reference model on every cycle, so the first wrong value is reported. A wrong synchronizer depth or drain count shifts the stop edge by one boundary, which the per-cycle comparison reports at that boundary.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;
    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_DRAIN = 2'd1,
        GS_HALT  = 2'd2
    } gate_state_e;
endpackage

// File: rtl/ckstop_sync.sv
module ckstop_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= async_i;
            hold_q <= meta_q;
        end
    end

    assign sync_o = hold_q;
endmodule

// File: rtl/ckstop_gate_fsm.sv
module ckstop_gate_fsm
    import ckstop_pkg::*;
#(
    parameter int LAT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic pass_o,
    output logic halted_o
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);
    localparam logic [CW-1:0] LOAD = CW'((LAT > 0) ? (LAT - 1) : 0);

    gate_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (state_q)
                GS_RUN: begin
                    if (req) begin
                        if (LAT == 0) begin
                            state_d = GS_HALT;
                        end else begin
                            state_d = GS_DRAIN;
                            cnt_d   = LOAD;
                        end
                    end
                end
                GS_DRAIN: begin
                    if (!req) begin
                        state_d = GS_RUN;
                    end else if (cnt_q == '0) begin
                        state_d = GS_HALT;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                GS_HALT: begin
                    if (!req) begin
                        state_d = GS_RUN;
                    end
                end
                default: state_d = GS_RUN;
            endcase
        end
    end

    always_comb begin
        pass_o   = (state_q != GS_HALT);
        halted_o = (state_q == GS_HALT);
    end

    AST_STATE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q)); // R9
    AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && tick && !req) |=> (state_q == GS_RUN)); // R4
    AST_DRAIN_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_DRAIN && tick && !req) |=> pass_o); // R10
endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl #(
    parameter int N_CPU        = 4,
    parameter int N_PCI        = 6,
    parameter int CPU_STOP_LAT = 2,
    parameter int CFG_W        = 16
) (
    input  logic             clk_master,
    input  logic             rst_n,
    input  logic             pm_bypass,
    input  logic             cpu_stop_a,
    input  logic             pci_stop_a,
    input  logic             pwr_down_a,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o
);
    localparam int USED     = N_CPU + N_PCI + 1;
    localparam int PCI_LO   = N_CPU;
    localparam int PCI_HI   = N_CPU + N_PCI - 1;
    localparam int FREE_BIT = N_CPU + N_PCI;

    logic [1:0]      phase_q;
    logic            cpu_tick, pci_tick;
    logic [2:0]      req_s;
    logic            cpu_req, pci_req, free_req;
    logic            cpu_pass, pci_pass, free_pass;
    logic            cpu_halted, pci_halted, free_halted;
    logic [USED-1:0] cfg_q;
    logic [N_CPU-1:0] cpu_en_q;
    logic [N_PCI-1:0] pci_en_q;
    logic            free_en_q;

    generate
        if (CFG_W > USED) begin : g_rsvd
            logic rsvd_unused;
            assign rsvd_unused = ^cfg_wdata[CFG_W-1:USED];
        end
    endgenerate

    // Phase counter: CPU high when phase is even, PCI high on phases 0 and 1
    always_ff @(posedge clk_master or negedge rst_n) begin
        if (!rst_n) phase_q <= 2'd0;
        else        phase_q <= phase_q + 2'd1;
    end

    always_comb begin
        cpu_tick = phase_q[0];
        pci_tick = (phase_q == 2'd3);
    end

    ckstop_sync #(.W(3)) u_sync (
        .clk     (clk_master),
        .rst_n   (rst_n),
        .async_i ({pwr_down_a, pci_stop_a, cpu_stop_a}),
        .sync_o  (req_s)
    );

    always_comb begin
        cpu_req  = !pm_bypass && (req_s[0] || req_s[2]);
        pci_req  = !pm_bypass && (req_s[1] || req_s[2]);
        free_req = !pm_bypass && req_s[2];
    end

    ckstop_gate_fsm #(.LAT(CPU_STOP_LAT)) u_cpu_fsm (
        .clk(clk_master), .rst_n(rst_n), .tick(cpu_tick), .req(cpu_req),
        .pass_o(cpu_pass), .halted_o(cpu_halted));
    ckstop_gate_fsm #(.LAT(0)) u_pci_fsm (
        .clk(clk_master), .rst_n(rst_n), .tick(pci_tick), .req(pci_req),
        .pass_o(pci_pass), .halted_o(pci_halted));
    ckstop_gate_fsm #(.LAT(0)) u_free_fsm (
        .clk(clk_master), .rst_n(rst_n), .tick(pci_tick), .req(free_req),
        .pass_o(free_pass), .halted_o(free_halted));

    // Configuration word and per-group boundary snapshots
    always_ff @(posedge clk_master or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '1;
            cpu_en_q  <= '1;
            pci_en_q  <= '1;
            free_en_q <= 1'b1;
        end else begin
            if (cfg_we)   cfg_q <= cfg_wdata[USED-1:0];
            if (cpu_tick) cpu_en_q <= cfg_q[N_CPU-1:0];
            if (pci_tick) begin
                pci_en_q  <= cfg_q[PCI_HI:PCI_LO];
                free_en_q <= cfg_q[FREE_BIT];
            end
        end
    end

    // Output flops
    always_ff @(posedge clk_master or negedge rst_n) begin
        if (!rst_n) begin
            cpu_clk_o  <= '0;
            pci_clk_o  <= '0;
            pci_free_o <= 1'b0;
        end else begin
            cpu_clk_o  <= cpu_pass ? (cpu_en_q & {N_CPU{~phase_q[0]}}) : '0;
            pci_clk_o  <= pci_pass ? (pci_en_q & {N_PCI{~phase_q[1]}}) : '0;
            pci_free_o <= free_pass && free_en_q && !phase_q[1];
        end
    end

    AST_CPU_SINGLE_HIGH: assert property (@(posedge clk_master) disable iff (!rst_n)
        (|cpu_clk_o) |=> (cpu_clk_o == '0)); // R2
    AST_FREE_HIGH_PAIR: assert property (@(posedge clk_master) disable iff (!rst_n)
        $rose(pci_free_o) |=> pci_free_o); // R9
    AST_FREE_LOW_PAIR: assert property (@(posedge clk_master) disable iff (!rst_n)
        $fell(pci_free_o) |=> !pci_free_o); // R9
    AST_CPU_HALT_LOW: assert property (@(posedge clk_master) disable iff (!rst_n)
        cpu_halted |-> (cpu_clk_o == '0)); // R3
    AST_PCI_HALT_LOW: assert property (@(posedge clk_master) disable iff (!rst_n)
        pci_halted |-> (pci_clk_o == '0)); // R5
    AST_PD_FREE_LOW: assert property (@(posedge clk_master) disable iff (!rst_n)
        free_halted |-> !pci_free_o); // R6
    AST_BYPASS_NO_STOP: assert property (@(posedge clk_master) disable iff (!rst_n)
        $past(pm_bypass) |-> !$rose(cpu_halted)); // R7
endmodule

// File: tb/ckstop_ctrl_test.sv
module ckstop_ctrl_test;
    localparam int NC  = 4;
    localparam int NP  = 6;
    localparam int LAT = 2;
    localparam int CW  = 16;
    localparam int NO  = NC + NP + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pm_bypass = 1'b0;
    logic          cpu_stop_a = 1'b0, pci_stop_a = 1'b0, pwr_down_a = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [NC-1:0] cpu_clk_o;
    logic [NP-1:0] pci_clk_o;
    logic          pci_free_o;

    int    checks = 0;
    int    fails = 0;
    string tag = "R1";

    ckstop_ctrl #(.N_CPU(NC), .N_PCI(NP), .CPU_STOP_LAT(LAT), .CFG_W(CW)) uut (
        .clk_master(clk), .rst_n(rst_n), .pm_bypass(pm_bypass),
        .cpu_stop_a(cpu_stop_a), .pci_stop_a(pci_stop_a), .pwr_down_a(pwr_down_a),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o));

    // Reference model state (0 run, 1 drain, 2 halted)
    int            mk, cst, cd, pst, fst, dummy;
    logic [2:0]    ms1, ms2;
    logic [10:0]   mcfg;
    logic [NC-1:0] mcen, ecpu;
    logic [NP-1:0] mpen, epci;
    logic          mfen, efree;
    logic          prev_lvl [NO];
    int            run_len  [NO];
    bit            first_run[NO];

    function automatic int step_st(input int st, inout int cnt, input bit req, input int lat);
        int nx;
        nx = st;
        case (st)
            0: if (req) begin
                   if (lat == 0) nx = 2;
                   else begin nx = 1; cnt = lat - 1; end
               end
            1: if (!req) nx = 0;
               else if (cnt == 0) nx = 2;
               else cnt = cnt - 1;
            default: nx = req ? 2 : 0;
        endcase
        return nx;
    endfunction

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", r, what, act, exp);
        end
    endtask

    task automatic mon_out(input int idx, input logic lvl, input int min_hi, input int max_hi,
                           input int min_lo);
        if (!rst_n) begin
            first_run[idx] = 1'b1; prev_lvl[idx] = 1'b0; run_len[idx] = 0;
        end else if (lvl != prev_lvl[idx]) begin
            if (!first_run[idx]) begin
                checks++;
                if ((prev_lvl[idx] && (run_len[idx] < min_hi || run_len[idx] > max_hi)) ||
                    (!prev_lvl[idx] && run_len[idx] < min_lo)) begin
                    fails++;
                    $display("FAIL R9 output %0d phase level %0b length act=%0d exp>=%0d",
                             idx, prev_lvl[idx], run_len[idx], prev_lvl[idx] ? min_hi : min_lo);
                end
            end
            first_run[idx] = 1'b0; prev_lvl[idx] = lvl; run_len[idx] = 1;
        end else begin
            run_len[idx]++;
        end
    endtask

    always @(posedge clk) begin
        logic [1:0] ph;
        bit rc, rp, rf;
        if (!rst_n) begin
            mk = 0; cst = 0; cd = 0; pst = 0; fst = 0; ms1 = '0; ms2 = '0;
            mcfg = '1; mcen = '1; mpen = '1; mfen = 1'b1;
            ecpu = '0; epci = '0; efree = 1'b0;
        end else begin
            ph = mk[1:0];
            ecpu  = (cst != 2) ? (mcen & {NC{ph == 2'd0 || ph == 2'd2}}) : '0;
            epci  = (pst != 2) ? (mpen & {NP{ph < 2'd2}}) : '0;
            efree = (fst != 2) && mfen && (ph < 2'd2);
            rc = !pm_bypass && (ms2[0] || ms2[2]);
            rp = !pm_bypass && (ms2[1] || ms2[2]);
            rf = !pm_bypass && ms2[2];
            if (ph == 2'd1 || ph == 2'd3) cst = step_st(cst, cd, rc, LAT);
            if (ph == 2'd3) begin
                pst = step_st(pst, dummy, rp, 0);
                fst = step_st(fst, dummy, rf, 0);
            end
            if (ph == 2'd1 || ph == 2'd3) mcen = mcfg[3:0];
            if (ph == 2'd3) begin mpen = mcfg[9:4]; mfen = mcfg[10]; end
            if (cfg_we) mcfg = cfg_wdata[10:0];
            ms2 = ms1;
            ms1 = {pwr_down_a, pci_stop_a, cpu_stop_a};
            mk = (mk + 1) % 4;
        end
        #2;
        chk(tag, "cpu_clk_o", int'(cpu_clk_o), int'(ecpu));
        chk(tag, "pci_clk_o", int'(pci_clk_o), int'(epci));
        chk(tag, "pci_free_o", int'(pci_free_o), int'(efree));
        for (int i = 0; i < NC; i++) mon_out(i, cpu_clk_o[i], 1, 1, 1);
        for (int i = 0; i < NP; i++) mon_out(NC + i, pci_clk_o[i], 2, 2, 2);
        mon_out(NO - 1, pci_free_o, 2, 2, 2);
    end

    int hc[NC];
    int hp[NP];
    int hf;

    task automatic window(input int n);
        for (int i = 0; i < NC; i++) hc[i] = 0;
        for (int i = 0; i < NP; i++) hp[i] = 0;
        hf = 0;
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #3;
            for (int i = 0; i < NC; i++) hc[i] += int'(cpu_clk_o[i]);
            for (int i = 0; i < NP; i++) hp[i] += int'(pci_clk_o[i]);
            hf += int'(pci_free_o);
        end
    endtask

    task automatic cycles(input int n);
        for (int c = 0; c < n; c++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL R1 watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        tag = "R1";
        repeat (3) @(posedge clk);
        #3;
        chk("R1", "reset cpu", int'(cpu_clk_o), 0);
        chk("R1", "reset pci", int'(pci_clk_o), 0);
        chk("R1", "reset free", int'(pci_free_o), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R1", "edge1 cpu", int'(cpu_clk_o), 15);
        chk("R1", "edge1 pci", int'(pci_clk_o), 63);
        chk("R1", "edge1 free", int'(pci_free_o), 1);
        @(posedge clk); #3;
        chk("R1", "edge2 cpu", int'(cpu_clk_o), 0);
        chk("R1", "edge2 pci", int'(pci_clk_o), 63);
        @(posedge clk); #3;
        chk("R1", "edge3 cpu", int'(cpu_clk_o), 15);
        chk("R1", "edge3 pci", int'(pci_clk_o), 0);

        tag = "R2";
        window(16);
        chk("R2", "run cpu0 highs", hc[0], 8);
        chk("R2", "run pci0 highs", hp[0], 8);
        chk("R2", "run free highs", hf, 8);

        tag = "R3";
        @(negedge clk); cpu_stop_a = 1'b1;
        cycles(12);
        window(16);
        chk("R3", "stopped cpu0 highs", hc[0], 0);
        chk("R3", "stopped cpu3 highs", hc[3], 0);
        chk("R3", "pci0 during cpu stop", hp[0], 8);

        tag = "R4";
        @(negedge clk); cpu_stop_a = 1'b0;
        cycles(8);
        window(16);
        chk("R4", "restarted cpu0 highs", hc[0], 8);

        tag = "R5";
        @(negedge clk); pci_stop_a = 1'b1;
        cycles(10);
        window(16);
        chk("R5", "stopped pci0 highs", hp[0], 0);
        chk("R5", "stopped pci5 highs", hp[5], 0);
        chk("R5", "free during pci stop", hf, 8);
        chk("R5", "cpu0 during pci stop", hc[0], 8);
        @(negedge clk); pci_stop_a = 1'b0;
        cycles(10);
        window(16);
        chk("R5", "restarted pci0 highs", hp[0], 8);

        tag = "R6";
        @(negedge clk); pwr_down_a = 1'b1;
        cycles(12);
        window(16);
        chk("R6", "pd cpu0 highs", hc[0], 0);
        chk("R6", "pd pci0 highs", hp[0], 0);
        chk("R6", "pd free highs", hf, 0);
        @(negedge clk); pwr_down_a = 1'b0;
        cycles(12);
        window(16);
        chk("R6", "after pd cpu0", hc[0], 8);
        chk("R6", "after pd free", hf, 8);

        tag = "R7";
        @(negedge clk);
        pm_bypass = 1'b1; cpu_stop_a = 1'b1; pci_stop_a = 1'b1; pwr_down_a = 1'b1;
        cycles(12);
        window(16);
        chk("R7", "bypass cpu0", hc[0], 8);
        chk("R7", "bypass pci0", hp[0], 8);
        chk("R7", "bypass free", hf, 8);
        @(negedge clk);
        cpu_stop_a = 1'b0; pci_stop_a = 1'b0; pwr_down_a = 1'b0;
        cycles(4);
        pm_bypass = 1'b0;
        cycles(8);

        tag = "R8";
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'hFFBD;
        @(negedge clk); cfg_we = 1'b0;
        cycles(8);
        window(16);
        chk("R8", "cfg cpu1 disabled", hc[1], 0);
        chk("R8", "cfg cpu0 enabled", hc[0], 8);
        chk("R8", "cfg pci2 disabled", hp[2], 0);
        chk("R8", "cfg pci0 enabled", hp[0], 8);
        chk("R8", "cfg free enabled", hf, 8);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'hFFFF;
        @(negedge clk); cfg_we = 1'b0;
        cycles(8);
        window(16);
        chk("R8", "reserved ignored cpu1", hc[1], 8);
        chk("R8", "reserved ignored pci2", hp[2], 8);

        tag = "R10";
        @(negedge clk); cpu_stop_a = 1'b1;
        window(2);
        begin
            int first_part;
            first_part = hc[0];
            @(negedge clk); cpu_stop_a = 1'b0;
            window(14);
            chk("R10", "short stop cpu0 highs", first_part + hc[0], 8);
        end
        cycles(8);
        finish_run();
    end
endmodule